// File: doc/BRIEF.md
# Blanking-Synchronized Row Address Update Controller

This block sits between a display processor and the character fetch path of a text video generator. The processor writes a new row start address, a small set of row attribute bits and a scan-line preset. The block does not apply the write at once. It raises a stall signal to the processor as soon as the write request appears, and holds that stall until horizontal blanking has run long enough to apply the write without disturbing the visible line. The write takes effect on a gated strobe. The same strobe is offered to the scan-line counter so that it can pick up its preset.

The block also drives the character column address. On every blanking interval, one character time after blanking begins, the column counter reloads from the committed row start register. During the active part of the line it then advances by one per character clock, up to a configurable last column. The blanking input is delayed on the character clock to derive two windows. The shorter window times the column reload. The longer one times the commit of a pending write. Both delays are parameters.

Top module: `rowupd_ctrl`

## Requirements
- R1: After reset the stall output, the gated strobe, the row start, attribute and preset registers and the column address are all zero.
- R2: The column address loads the current row start register on the clock edge at which blank_i is high and blank_i delayed by one character clock is also high. That is the second edge of a blanking interval, and the load repeats on every later edge of the same interval.
- R3: While blank_i is low, the column address increases by one per clock, wrapping modulo 2^ADDR_W. After LINE_COLS-1 increments since the last load it holds at that value.
- R4: On the first clock of a blanking interval, when no load condition is met, the column address holds.
- R5: wait_o is high in the same cycle as wr_req_i whenever the pending write has not yet been committed. It is combinational from wr_req_i.
- R6: wr_strobe_o is high only when wr_req_i is high, blank_i is high, blank_i delayed by two character clocks is high, and the write has not yet been committed. It is high for exactly one cycle per write request.
- R7: On the edge where wr_strobe_o is high, row_start_o, row_attr_o and scan_preset_o take row_addr_i, row_attr_i and scan_preset_i.
- R8: wait_o goes low on the clock edge after the commit and stays low while wr_req_i stays high. A new stall needs wr_req_i to go low and then high again.
- R9: Without a commit, the row start, attribute and preset registers keep their values, and every blanking interval reloads the column address with the same row start.
- R10: A blanking interval of fewer than three character clocks never commits a pending write, and the stall continues into the next interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blank_i | input | 1 | Horizontal blanking, high during retrace |
| wr_req_i | input | 1 | Decoded processor write to the row start register, held while stalled |
| row_addr_i | input | ADDR_W (12) | New row start address |
| row_attr_i | input | ATTR_W (4) | New row attribute bits |
| scan_preset_i | input | SCAN_W (4) | New scan-line counter preset |
| wait_o | output | 1 | Stall request to the processor |
| wr_strobe_o | output | 1 | Gated commit strobe, also the scan-line counter load |
| row_start_o | output | ADDR_W (12) | Committed row start address |
| row_attr_o | output | ATTR_W (4) | Committed row attributes |
| scan_preset_o | output | SCAN_W (4) | Committed scan-line preset |
| col_addr_o | output | ADDR_W (12) | Character column address |

## Verification
The bench issues a write during the active line and keeps it held into blanking. A design that committed on the reload window instead of the two-character window would pulse the strobe one cycle early, and a design that ignored blanking would commit in the middle of the line. A two-cycle blanking pulse with a write pending is aimed at designs that commit on any blanking. Holding the request after the commit catches a stall that re-arms, or a strobe that repeats. Long active lines and a row start near the top of the address space test the stop at the last column and the modulo wrap. A commit that lands together with a reload checks that the column takes the old row start first and the new one on the next edge.

// File: rtl/rowupd_pkg.sv
package rowupd_pkg;

   // Handshake state of the processor stall logic
   typedef enum logic [1:0] {
      WS_IDLE  = 2'd0,   // no request outstanding
      WS_STALL = 2'd1,   // request seen, processor held
      WS_DONE  = 2'd2    // committed, waiting for request to drop
   } wait_state_e;

   // Width needed to count up to n (at least one bit)
   function automatic int unsigned cnt_width(input int unsigned n);
      int unsigned w;
      w = 1;
      while ((1 << w) < n) w++;
      return w;
   endfunction

endpackage

// File: rtl/rowupd_blank_pipe.sv
// Chain of character-clock delays of the blanking input.
// taps_o[k-1] is blank delayed by k character clocks.
module rowupd_blank_pipe #(
   parameter int unsigned DEPTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             blank_i,
   output logic [DEPTH-1:0] taps_o
);

   logic [DEPTH-1:0] stage_q;

   for (genvar k = 0; k < DEPTH; k++) begin : g_stage
      if (k == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q[k] <= 1'b0;
            else        stage_q[k] <= blank_i;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q[k] <= 1'b0;
            else        stage_q[k] <= stage_q[k-1];
         end
      end
   end

   assign taps_o = stage_q;

endmodule

// File: rtl/rowupd_wait_ctl.sv
// Stall and commit handshake for the processor write.
module rowupd_wait_ctl
   import rowupd_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic wr_req_i,
   input  logic window_i,   // safe commit window
   output logic wait_o,
   output logic commit_o
);

   wait_state_e state_q, state_d;
   logic        not_done;

   assign not_done = (state_q != WS_DONE);
   assign wait_o   = wr_req_i && not_done;
   assign commit_o = wr_req_i && not_done && window_i;

   always_comb begin
      state_d = state_q;
      if (!wr_req_i)              state_d = WS_IDLE;
      else if (commit_o)          state_d = WS_DONE;
      else if (state_q == WS_IDLE) state_d = WS_STALL;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= WS_IDLE;
      else        state_q <= state_d;
   end

endmodule

// File: rtl/rowupd_row_regs.sv
// Committed row start, attribute and scan preset registers.
module rowupd_row_regs #(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned ATTR_W = 4,
   parameter int unsigned SCAN_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [ATTR_W-1:0] attr_i,
   input  logic [SCAN_W-1:0] preset_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [ATTR_W-1:0] attr_o,
   output logic [SCAN_W-1:0] preset_o
);

   localparam int unsigned TOT_W = ADDR_W + ATTR_W + SCAN_W;

   logic [TOT_W-1:0] img_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        img_q <= '0;
      else if (commit_i) img_q <= {addr_i, attr_i, preset_i};
   end

   assign {addr_o, attr_o, preset_o} = img_q;

endmodule

// File: rtl/rowupd_col_ctr.sv
// Character column address: reloads in blanking, advances in the active line.
module rowupd_col_ctr
   import rowupd_pkg::*;
#(
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned LINE_COLS   = 80,
   parameter bit          STOP_AT_END = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              blank_i,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] start_i,
   output logic [ADDR_W-1:0] col_o
);

   logic [ADDR_W-1:0] col_q;
   logic              adv_ok;
   logic              step;

   assign step = !load_i && !blank_i && adv_ok;

   if (STOP_AT_END) begin : g_stop
      localparam int unsigned          POS_W    = cnt_width(LINE_COLS);
      localparam logic [POS_W-1:0]     LAST_POS = POS_W'(LINE_COLS - 1);
      logic [POS_W-1:0] pos_q;

      assign adv_ok = (pos_q != LAST_POS);

      always_ff @(posedge clk) begin
         if (!rst_n)      pos_q <= '0;
         else if (load_i) pos_q <= '0;
         else if (step)   pos_q <= pos_q + 1'b1;
      end
   end else begin : g_free
      assign adv_ok = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      col_q <= '0;
      else if (load_i) col_q <= start_i;
      else if (step)   col_q <= col_q + 1'b1;
   end

   assign col_o = col_q;

endmodule

// File: rtl/rowupd_ctrl.sv
// Top: row address update controller synchronized to horizontal blanking.
module rowupd_ctrl #(
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned ATTR_W      = 4,
   parameter int unsigned SCAN_W      = 4,
   parameter int unsigned LINE_COLS   = 80,
   parameter bit          STOP_AT_END = 1'b1,
   parameter int unsigned LOAD_DLY    = 1,   // reload window delay, char clocks
   parameter int unsigned COMMIT_DLY  = 2    // commit window delay, char clocks
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              blank_i,
   input  logic              wr_req_i,
   input  logic [ADDR_W-1:0] row_addr_i,
   input  logic [ATTR_W-1:0] row_attr_i,
   input  logic [SCAN_W-1:0] scan_preset_i,
   output logic              wait_o,
   output logic              wr_strobe_o,
   output logic [ADDR_W-1:0] row_start_o,
   output logic [ATTR_W-1:0] row_attr_o,
   output logic [SCAN_W-1:0] scan_preset_o,
   output logic [ADDR_W-1:0] col_addr_o
);

   localparam int unsigned PIPE_D = COMMIT_DLY;

   // elaboration-time parameter checks
   if (ADDR_W < 2) begin : g_bad_addr
      $error("rowupd_ctrl: ADDR_W must be at least 2");
   end
   if (LOAD_DLY < 1) begin : g_bad_load
      $error("rowupd_ctrl: LOAD_DLY must be at least 1");
   end
   if (COMMIT_DLY <= LOAD_DLY) begin : g_bad_commit
      $error("rowupd_ctrl: COMMIT_DLY must exceed LOAD_DLY");
   end
   if (LINE_COLS < 2 || LINE_COLS > (1 << ADDR_W)) begin : g_bad_cols
      $error("rowupd_ctrl: LINE_COLS out of range");
   end

   logic [PIPE_D-1:0] blank_taps;
   logic              load_win;
   logic              commit_win;
   logic              commit;

   rowupd_blank_pipe #(.DEPTH(PIPE_D)) u_pipe (
      .clk     (clk),
      .rst_n   (rst_n),
      .blank_i (blank_i),
      .taps_o  (blank_taps)
   );

   assign load_win   = blank_i && blank_taps[LOAD_DLY-1];
   assign commit_win = blank_i && blank_taps[COMMIT_DLY-1];

   rowupd_wait_ctl u_wait (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_req_i (wr_req_i),
      .window_i (commit_win),
      .wait_o   (wait_o),
      .commit_o (commit)
   );

   rowupd_row_regs #(
      .ADDR_W (ADDR_W),
      .ATTR_W (ATTR_W),
      .SCAN_W (SCAN_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .commit_i (commit),
      .addr_i   (row_addr_i),
      .attr_i   (row_attr_i),
      .preset_i (scan_preset_i),
      .addr_o   (row_start_o),
      .attr_o   (row_attr_o),
      .preset_o (scan_preset_o)
   );

   rowupd_col_ctr #(
      .ADDR_W      (ADDR_W),
      .LINE_COLS   (LINE_COLS),
      .STOP_AT_END (STOP_AT_END)
   ) u_col (
      .clk     (clk),
      .rst_n   (rst_n),
      .blank_i (blank_i),
      .load_i  (load_win),
      .start_i (row_start_o),
      .col_o   (col_addr_o)
   );

   assign wr_strobe_o = commit;

endmodule

// File: rtl/rowupd_ctrl_chk.sv
// Property checker for rowupd_ctrl, attached by bind.
module rowupd_ctrl_chk #(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned LINE_COLS = 80
) (
   input logic              clk,
   input logic              rst_n,
   input logic              blank_i,
   input logic              wr_req_i,
   input logic [ADDR_W-1:0] row_addr_i,
   input logic              wait_o,
   input logic              wr_strobe_o,
   input logic [ADDR_W-1:0] row_start_o,
   input logic [ADDR_W-1:0] col_addr_o
);

   logic [1:0]  blank_run;   // consecutive blank cycles seen, saturating
   logic [31:0] adv_cnt;     // increments since last reload

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         blank_run <= 2'd0;
         adv_cnt   <= 32'd0;
      end else begin
         if (!blank_i)                blank_run <= 2'd0;
         else if (blank_run != 2'd3)  blank_run <= blank_run + 2'd1;
         if (blank_i && blank_run != 2'd0)
            adv_cnt <= 32'd0;
         else if (!blank_i && adv_cnt < LINE_COLS - 1)
            adv_cnt <= adv_cnt + 32'd1;
      end
   end

   // R6: commit only deep enough inside blanking, and only with a request
   p_strobe_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe_o |-> (blank_i && blank_run >= 2'd2 && wr_req_i));

   // R7: commit captures the presented address
   p_row_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe_o |=> (row_start_o == $past(row_addr_i)));

   // R9: no commit, no change of the row start
   p_row_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_strobe_o |=> $stable(row_start_o));

   // R8: stall released after the commit edge
   p_wait_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe_o |=> !wait_o);

   // R5: stall never without a request
   p_wait_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wait_o |-> wr_req_i);

   // R4: first blank cycle holds the column
   p_col_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (blank_i && blank_run == 2'd0) |=> $stable(col_addr_o));

   // R3: active line advances until the last column
   p_col_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!blank_i && adv_cnt < LINE_COLS - 1) |=> (col_addr_o == $past(col_addr_o) + 1'b1));

   // R3: column holds at the end of the line
   p_col_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!blank_i && adv_cnt == LINE_COLS - 1) |=> $stable(col_addr_o));

   // R2: reload window copies the row start
   p_col_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (blank_i && blank_run != 2'd0 && !wr_strobe_o) |=> (col_addr_o == $past(row_start_o)));

endmodule

bind rowupd_ctrl rowupd_ctrl_chk #(
   .ADDR_W    (ADDR_W),
   .LINE_COLS (LINE_COLS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .blank_i     (blank_i),
   .wr_req_i    (wr_req_i),
   .row_addr_i  (row_addr_i),
   .wait_o      (wait_o),
   .wr_strobe_o (wr_strobe_o),
   .row_start_o (row_start_o),
   .col_addr_o  (col_addr_o)
);

// File: tb/tb_rowupd_ctrl.sv
`timescale 1ns/100ps
module tb_rowupd_ctrl;

   localparam int AW = 12;
   localparam int TW = 4;
   localparam int SW = 4;
   localparam int COLS = 80;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          blank = 1'b0;
   logic          wr = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [TW-1:0] attr = '0;
   logic [SW-1:0] pre = '0;
   logic          wait_s, strobe_s;
   logic [AW-1:0] row_s, col_s;
   logic [TW-1:0] attr_s;
   logic [SW-1:0] pre_s;

   always #2.5 clk = ~clk;

   rowupd_ctrl dut (
      .clk(clk), .rst_n(rst_n), .blank_i(blank), .wr_req_i(wr),
      .row_addr_i(addr), .row_attr_i(attr), .scan_preset_i(pre),
      .wait_o(wait_s), .wr_strobe_o(strobe_s), .row_start_o(row_s),
      .row_attr_o(attr_s), .scan_preset_o(pre_s), .col_addr_o(col_s)
   );

   typedef struct {
      string         tag;
      logic          w;
      logic          s;
      logic [AW-1:0] row;
      logic [TW-1:0] at;
      logic [SW-1:0] pr;
      logic [AW-1:0] col;
   } exp_t;

   exp_t q[$];
   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // reference state, built from the requirements
   logic          m_d1 = 0, m_d2 = 0, m_done = 0;
   logic [AW-1:0] m_row = '0, m_col = '0;
   logic [TW-1:0] m_at = '0;
   logic [SW-1:0] m_pr = '0;
   int            m_pos = 0;

   task automatic chk(input string tag, input string fld, input int got, input int exp);
      n_cmp++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0h expected %0h at %0t", tag, fld, got, exp, $time);
      end
   endtask

   // driver: one character clock of stimulus plus its expected outputs
   task automatic cyc(input string tag, input logic b, input logic w,
                      input logic [AW-1:0] a = '0, input logic [TW-1:0] t = '0,
                      input logic [SW-1:0] p = '0);
      exp_t e;
      logic ld, cm;
      @(negedge clk);
      rst_n = 1'b1;
      blank = b; wr = w; addr = a; attr = t; pre = p;
      ld = b && m_d1;                 // R2 reload window
      cm = w && b && m_d2 && !m_done;  // R6 commit window
      e.tag = tag; e.w = w && !m_done; e.s = cm;
      e.row = m_row; e.at = m_at; e.pr = m_pr; e.col = m_col;
      q.push_back(e);
      // state after the coming edge
      if (ld) begin m_col = m_row; m_pos = 0; end
      else if (!b && m_pos < COLS - 1) begin m_col = m_col + 1'b1; m_pos++; end
      if (cm) begin m_row = a; m_at = t; m_pr = p; end
      m_done = cm ? 1'b1 : (w ? m_done : 1'b0);
      m_d2 = m_d1; m_d1 = b;
   endtask

   // monitor: compares each cycle's outputs against the queue
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(e.tag, "wait", wait_s, e.w);
            chk(e.tag, "strobe", strobe_s, e.s);
            chk(e.tag, "row", row_s, e.row);
            chk(e.tag, "attr", attr_s, e.at);
            chk(e.tag, "preset", pre_s, e.pr);
            chk(e.tag, "col", col_s, e.col);
         end
      end
   end

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset values
      cyc("R1", 0, 0);
      // R3: active line, counting from zero
      for (int i = 0; i < 10; i++) cyc("R3", 0, 0);
      // R4 then R2: blanking with no write, column reloads row start; R9 keeps it
      cyc("R4", 1, 0);
      for (int i = 0; i < 4; i++) cyc("R2", 1, 0);
      for (int i = 0; i < 3; i++) cyc("R9", 0, 0);
      // R5: write issued mid-line stalls at once
      for (int i = 0; i < 4; i++) cyc("R5", 0, 1, 12'h1A0, 4'h5, 4'h3);
      // R6, R7: commit on the third blank cycle
      for (int i = 0; i < 6; i++) cyc("R6", 1, 1, 12'h1A0, 4'h5, 4'h3);
      // R8: request still held, no new stall
      for (int i = 0; i < 3; i++) cyc("R8", 0, 1, 12'h1A0, 4'h5, 4'h3);
      for (int i = 0; i < 6; i++) cyc("R7", 0, 0);
      // R9: further blanking with no write
      for (int i = 0; i < 4; i++) cyc("R9", 1, 0, 12'h777, 4'hF, 4'hF);
      for (int i = 0; i < 3; i++) cyc("R9", 0, 0, 12'h777, 4'hF, 4'hF);
      // R10: short blanking with a write pending
      for (int i = 0; i < 2; i++) cyc("R5", 0, 1, 12'h2B4, 4'hA, 4'h9);
      for (int i = 0; i < 2; i++) cyc("R10", 1, 1, 12'h2B4, 4'hA, 4'h9);
      for (int i = 0; i < 3; i++) cyc("R10", 0, 1, 12'h2B4, 4'hA, 4'h9);
      for (int i = 0; i < 5; i++) cyc("R6", 1, 1, 12'h2B4, 4'hA, 4'h9);
      cyc("R8", 1, 0);
      // R3: long line stops at the last column
      for (int i = 0; i < 90; i++) cyc("R3", 0, 0);
      // R3 wrap: commit near the top of the address range
      for (int i = 0; i < 2; i++) cyc("R5", 0, 1, 12'hFFE, 4'h1, 4'h0);
      for (int i = 0; i < 5; i++) cyc("R7", 1, 1, 12'hFFE, 4'h1, 4'h0);
      for (int i = 0; i < 6; i++) cyc("R3", 0, 0);
      for (int i = 0; i < 4; i++) cyc("R2", 1, 0);
      cyc("R9", 0, 0);
      repeat (3) @(negedge clk);
      done = 1'b1;
      finish_run();
   end

endmodule